// File: doc/BRIEF.md
# Transmit Status and Interrupt Flag Register

This block holds the 8-bit transmit status byte of a token-passing network controller. The protocol engine reports events on single-cycle pulse inputs, and each event sets a sticky flag. Software reads the byte on `rd_data` and clears a flag by writing a 1 to its bit. The transmit-error flag and the no-response flag also clear when a new send command is issued. A software reset pulse clears every flag.

Two bits are not sticky. Bit 3 is a registered summary of the masked core interrupt sources. Bit 0 shows the transmitter-available state, which a two-state sequencer produces. In state `ST_READY` bit 0 follows the core's transmitter-available input. The transition READY→SENDING is taken on `send_cmd`. In state `ST_SENDING` bit 0 reads 0. The transition SENDING→READY is taken on `tx_done` or on a software reset.

When a send command is issued, the block also checks the page-pointer field of the outgoing packet. It sets an error flag if the pointer is below 3 or does not fall inside the page.

Top module: `txstat_reg`

## Requirements
- R1: Bit layout, from bit 7 down to bit 0: token retry, ACK/NAK countermeasure, hub watchdog timeout, invalid pointer, interrupt summary, no response to free-buffer enquiry, transmit error (1 means the send failed), transmitter available. A pulse on `ev_tkn_retry`, `ev_acknak_fix`, `ev_hub_wdt` or `ev_tx_fail` sets bit 7, 6, 5 or 1 respectively, and the flag is visible on `rd_data` after the next clock edge.
- R2: A write (`wr_en`=1) with a 1 in bit 7, 6, 5, 4, 2 or 1 clears that flag at the next clock edge.
- R3: Writing 0 to a bit has no effect. A write to bit 3 or bit 0 has no effect.
- R4: If a set event and a clear (write-1 or send command) reach the same flag in the same cycle, the flag is set.
- R5: A `send_cmd` pulse clears bits 2 and 1 and leaves bits 7..4 unchanged.
- R6: A pulse on `ev_fbe_noresp` sets bit 2 and bit 1 together.
- R7: A `sw_rst` pulse clears bits 7..1 and returns the sequencer to `ST_READY`. It takes priority over set events in the same cycle.
- R8: Bit 3 equals, one clock later, the OR of the source/mask pairs. `irq_src[0]` is excessive NAK, `irq_src[1]` is reconfiguration, `irq_src[2]` is next-ID error and `irq_mask[3]` enables the transmitter-available bit; `irq_mask[i]` enables source i.
- R9: Bit 0 reads `core_ta` in `ST_READY`. It reads 0 from the edge that takes `send_cmd` until the edge that takes `tx_done`.
- R10: On `send_cmd`, bit 4 is set at the next edge if `pkt_ptr` < 3 or `pkt_ptr` >= `page_size`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_rst | input | 1 | Software reset pulse |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data, 1 bits clear flags |
| rd_data | output | 8 | Status byte |
| ev_tkn_retry | input | 1 | Token retry event |
| ev_acknak_fix | input | 1 | ACK/NAK countermeasure event |
| ev_hub_wdt | input | 1 | Hub watchdog timeout event |
| ev_tx_fail | input | 1 | Send failure event |
| ev_fbe_noresp | input | 1 | No response to free-buffer enquiry |
| irq_src | input | 3 | Core interrupt sources (level) |
| irq_mask | input | 4 | Interrupt enables |
| core_ta | input | 1 | Core transmitter-available status |
| send_cmd | input | 1 | Send command pulse |
| tx_done | input | 1 | Send finished pulse |
| pkt_ptr | input | 8 | Packet page-pointer field |
| page_size | input | 9 | Page size in bytes |

## Verification
Every sticky flag, the invalid-pointer flag, the interrupt summary and the sequencer state pass through exactly one register. A stimulus is therefore visible on `rd_data` one edge after it is applied. Bit 0 is combinational from the registered state and `core_ta`, so a change of `core_ta` alone is visible in the same cycle. The bench drives each stimulus on a falling edge and removes the pulses on the following falling edge. It checks `rd_data` at that point, after exactly one rising edge.

// File: rtl/txstat_pkg.sv
package txstat_pkg;
    localparam int REG_W = 8;
    // bits that hold a sticky flag (7,6,5,4,2,1)
    localparam logic [REG_W-1:0] STICKY_MASK   = 8'b1111_0110;
    // sticky bits also cleared by a send command
    localparam logic [REG_W-1:0] SEND_CLR_MASK = 8'b0000_0110;
    localparam int BIT_IRQ = 3;
    localparam int BIT_TA  = 0;
    localparam int NUM_IRQ = 4;

    typedef enum logic {
        ST_READY   = 1'b0,
        ST_SENDING = 1'b1
    } seq_state_t;
endpackage

// File: rtl/txstat_flag.sv
module txstat_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_rst,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      q_o <= 1'b0;
        else if (sw_rst) q_o <= 1'b0;
        else if (set_i)  q_o <= 1'b1;   // set beats clear
        else if (clr_i)  q_o <= 1'b0;
    end
endmodule

// File: rtl/txstat_ptr_chk.sv
module txstat_ptr_chk #(
    parameter int PTR_W   = 8,
    parameter int PG_W    = 9,
    parameter int PTR_MIN = 3
) (
    input  logic [PTR_W-1:0] pkt_ptr,
    input  logic [PG_W-1:0]  page_size,
    output logic             bad_o
);
    localparam logic [PG_W-1:0] MIN_V = PG_W'(PTR_MIN);
    logic [PG_W-1:0] ptr_ext;

    assign ptr_ext = PG_W'(pkt_ptr);

    always_comb begin
        bad_o = (ptr_ext < MIN_V) || (ptr_ext >= page_size);
    end
endmodule

// File: rtl/txstat_seq.sv
module txstat_seq
    import txstat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sw_rst,
    input  logic send_cmd,
    input  logic tx_done,
    input  logic core_ta,
    output logic ta_o
);
    seq_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_READY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (sw_rst) begin
            state_d = ST_READY;
        end else begin
            unique case (state_q)
                ST_READY:   if (send_cmd) state_d = ST_SENDING;
                ST_SENDING: if (tx_done)  state_d = ST_READY;
                default:    state_d = ST_READY;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            ST_READY:   ta_o = core_ta;
            ST_SENDING: ta_o = 1'b0;
            default:    ta_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/txstat_reg.sv
module txstat_reg
    import txstat_pkg::*;
#(
    parameter int PTR_W   = 8,
    parameter int PG_W    = 9,
    parameter int PTR_MIN = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             ev_tkn_retry,
    input  logic             ev_acknak_fix,
    input  logic             ev_hub_wdt,
    input  logic             ev_tx_fail,
    input  logic             ev_fbe_noresp,
    input  logic [2:0]       irq_src,
    input  logic [3:0]       irq_mask,
    input  logic             core_ta,
    input  logic             send_cmd,
    input  logic             tx_done,
    input  logic [PTR_W-1:0] pkt_ptr,
    input  logic [PG_W-1:0]  page_size
);
    logic [REG_W-1:0]   set_v, clr_v, flag_q;
    logic [NUM_IRQ-1:0] irq_vec;
    logic ptr_bad, ta_bit, com_q;

    txstat_ptr_chk #(.PTR_W(PTR_W), .PG_W(PG_W), .PTR_MIN(PTR_MIN)) u_ptr (
        .pkt_ptr(pkt_ptr), .page_size(page_size), .bad_o(ptr_bad)
    );

    txstat_seq u_seq (
        .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .send_cmd(send_cmd),
        .tx_done(tx_done), .core_ta(core_ta), .ta_o(ta_bit)
    );

    always_comb begin
        set_v    = '0;
        set_v[7] = ev_tkn_retry;
        set_v[6] = ev_acknak_fix;
        set_v[5] = ev_hub_wdt;
        set_v[4] = send_cmd & ptr_bad;
        set_v[2] = ev_fbe_noresp;
        set_v[1] = ev_tx_fail | ev_fbe_noresp;
        clr_v    = (wr_en ? wr_data : '0) | (send_cmd ? SEND_CLR_MASK : '0);
    end

    assign irq_vec = {ta_bit, irq_src};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      com_q <= 1'b0;
        else if (sw_rst) com_q <= 1'b0;
        else             com_q <= |(irq_vec & irq_mask);
    end

    for (genvar g = 0; g < REG_W; g++) begin : g_bit
        if (STICKY_MASK[g]) begin : g_sticky
            txstat_flag u_flag (
                .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst),
                .set_i(set_v[g]), .clr_i(clr_v[g]), .q_o(flag_q[g])
            );
        end else if (g == BIT_IRQ) begin : g_irq
            assign flag_q[g] = com_q;
        end else begin : g_ta
            assign flag_q[g] = ta_bit;
        end
    end

    assign rd_data = flag_q;
endmodule

// File: rtl/txstat_chk.sv
module txstat_chk #(
    parameter int PTR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sw_rst,
    input logic             wr_en,
    input logic [7:0]       wr_data,
    input logic [7:0]       rd_data,
    input logic             ev_tkn_retry,
    input logic             ev_hub_wdt,
    input logic             ev_tx_fail,
    input logic             ev_fbe_noresp,
    input logic [2:0]       irq_src,
    input logic [3:0]       irq_mask,
    input logic             send_cmd,
    input logic             tx_done,
    input logic [PTR_W-1:0] pkt_ptr
);
    // R1
    hub_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_hub_wdt && !sw_rst |=> rd_data[5]);
    // R2
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_data[7] && !ev_tkn_retry && !sw_rst |=> !rd_data[7]);
    // R4
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tx_fail && (send_cmd || (wr_en && wr_data[1])) && !sw_rst |=> rd_data[1]);
    // R5
    send_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        send_cmd && !ev_tx_fail && !ev_fbe_noresp && !sw_rst |=> !rd_data[2] && !rd_data[1]);
    // R6
    fbe_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_fbe_noresp && !sw_rst |=> rd_data[2] && rd_data[1]);
    // R7
    swrst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |=> rd_data[7:1] == 7'd0);
    // R8
    irq_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|({rd_data[0], irq_src} & irq_mask)) && !sw_rst |=> rd_data[3]);
    // R9
    ta_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        send_cmd && !tx_done && !sw_rst |=> !rd_data[0]);
    // R10
    ptr_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        send_cmd && !sw_rst && (pkt_ptr < PTR_W'(3)) |=> rd_data[4]);
endmodule

bind txstat_reg txstat_chk #(.PTR_W(PTR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .ev_tkn_retry(ev_tkn_retry),
    .ev_hub_wdt(ev_hub_wdt), .ev_tx_fail(ev_tx_fail),
    .ev_fbe_noresp(ev_fbe_noresp), .irq_src(irq_src), .irq_mask(irq_mask),
    .send_cmd(send_cmd), .tx_done(tx_done), .pkt_ptr(pkt_ptr)
);

// File: tb/test_txstat_reg.sv
`timescale 1ns/1ps
module test_txstat_reg;
    logic clk = 1'b0, rst_n = 1'b0, sw_rst = 1'b0, wr_en = 1'b0;
    logic [7:0] wr_data = '0, rd_data;
    logic ev_tkn_retry = 0, ev_acknak_fix = 0, ev_hub_wdt = 0, ev_tx_fail = 0, ev_fbe_noresp = 0;
    logic [2:0] irq_src = '0;
    logic [3:0] irq_mask = '0;
    logic core_ta = 1'b1, send_cmd = 1'b0, tx_done = 1'b0;
    logic [7:0] pkt_ptr = 8'h10;
    logic [8:0] page_size = 9'd256;
    int n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    txstat_reg i_txstat_reg (.*);

    // fields: [21:17] events {tkn,acknak,hub,txfail,fbe}, [16] wr_en, [15:8] wr_data, [7:0] expected
    localparam logic [21:0] VEC [11] = '{
        {5'b10000, 1'b0, 8'h00, 8'h81},
        {5'b01000, 1'b0, 8'h00, 8'hC1},
        {5'b00100, 1'b0, 8'h00, 8'hE1},
        {5'b00010, 1'b0, 8'h00, 8'hE3},
        {5'b00000, 1'b1, 8'h80, 8'h63},
        {5'b00000, 1'b1, 8'h00, 8'h63},
        {5'b00001, 1'b0, 8'h00, 8'h67},
        {5'b00000, 1'b1, 8'h06, 8'h61},
        {5'b00000, 1'b1, 8'h09, 8'h61},
        {5'b10000, 1'b1, 8'h80, 8'hE1},
        {5'b00000, 1'b1, 8'hFF, 8'h01}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: rd_data=%h expected %h", req, act, exp);
        end
    endtask

    // inputs set at a falling edge are taken at the next rising edge; pulses drop at the falling edge after it
    task automatic tick();
        @(negedge clk);
        {ev_tkn_retry, ev_acknak_fix, ev_hub_wdt, ev_tx_fail, ev_fbe_noresp} = '0;
        {wr_en, send_cmd, tx_done, sw_rst} = '0;
        wr_data = '0;
    endtask

    task automatic do_send(input logic [7:0] p);
        pkt_ptr = p; send_cmd = 1'b1; tick();
    endtask

    task automatic do_write(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d; tick();
    endtask

    task automatic finish_send();
        tx_done = 1'b1; tick();
    endtask

    initial begin
        #100000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: rd_data=%h expected end of run", rd_data);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", rd_data, 8'h01);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 11; i++) begin
            {ev_tkn_retry, ev_acknak_fix, ev_hub_wdt, ev_tx_fail, ev_fbe_noresp} = VEC[i][21:17];
            wr_en = VEC[i][16]; wr_data = VEC[i][15:8];
            tick();
            check($sformatf("R1,R2,R3,R4,R6 vec%0d", i), rd_data, VEC[i][7:0]);
        end

        // R5 send clears bits 2,1 only; R9 bit0 low while sending
        ev_hub_wdt = 1; ev_fbe_noresp = 1; tick();
        check("R6 fbe", rd_data, 8'h27);
        do_send(8'h10);
        check("R5 send clear", rd_data, 8'h20);
        check("R9 sending", {7'd0, rd_data[0]}, 8'h00);
        finish_send();
        check("R9 done", rd_data, 8'h21);

        // R7 sw reset
        ev_tkn_retry = 1; sw_rst = 1; tick();
        check("R7 swrst", rd_data, 8'h01);
        do_send(8'h20);
        sw_rst = 1; tick();
        check("R7 seq ready", rd_data, 8'h01);

        // R10 pointer check
        do_send(8'h01);
        check("R10 low ptr", rd_data, 8'h10);
        finish_send();
        do_write(8'h10);
        check("R10 cleared", rd_data, 8'h01);
        page_size = 9'd128;
        do_send(8'h90);
        check("R10 past page", rd_data, 8'h10);
        finish_send(); do_write(8'h10);
        do_send(8'h7F);
        check("R10 last valid", rd_data, 8'h00);
        finish_send();
        page_size = 9'd256;
        do_send(8'h03);
        check("R10 min valid", rd_data, 8'h00);
        finish_send();

        // R4 set vs send clear
        ev_tx_fail = 1; pkt_ptr = 8'h10; send_cmd = 1; tick();
        check("R4 set beats send", rd_data, 8'h02);
        finish_send(); do_write(8'h02);

        // R8 interrupt summary
        irq_mask = 4'b0001; irq_src = 3'b001; tick();
        check("R8 excnak", rd_data, 8'h09);
        do_write(8'h08);
        check("R3 bit3 write", rd_data, 8'h09);
        irq_mask = 4'b0110; irq_src = 3'b001; tick();
        check("R8 masked", rd_data, 8'h01);
        irq_src = 3'b100; tick();
        check("R8 nxtid", rd_data, 8'h09);
        irq_src = 3'b000; irq_mask = 4'b1000; tick();
        check("R8 ta src", rd_data, 8'h09);
        core_ta = 1'b0; tick();
        check("R9 core ta low", rd_data, 8'h00);
        do_write(8'h01);
        check("R3 bit0 write", rd_data, 8'h00);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule